// File: doc/BRIEF.md
# Flyback Fault Supervisor with Auto-Restart and Latch Classes

This block supervises power-up and protection for an offline flyback controller. Upstream comparators provide digital flags for the supply rail, the sampled output voltage, the line-sense current, die temperature and an external shutdown input. The block turns those flags into two enables. One enable lets the PWM switch. The other turns on the high-voltage startup current source. It also reports the fault that stopped switching.

Protection events fall into two classes, and each class clears at a different supply level. An auto-restart fault stops switching until the rail collapses to the turn-off level. The startup source then recharges the rail and switching resumes at the turn-on level. A latched fault also stops switching, but it survives any number of these recharge hiccups. Only a deeper collapse of the rail, down to the release level, clears it. Two of the faults are debounced over switching cycles. The brownout fault and the under-voltage blanking window are timed in millisecond ticks. A programmable prescaler derives those ticks from the system clock.

Top module: `fault_supervisor`

## Requirements
- R1: During and after synchronous reset, `pwm_en`=0, `hvsrc_en`=1 and `fault_code`=0.
- R2: With no latched fault stored, `sup_on`=1 while charging sets `pwm_en`=1 and `hvsrc_en`=0 on the next clock. The two enables are never high together.
- R3: While switching, `sup_run`=0 stops switching and re-enables the startup source on the next clock. Dropping only `sup_on` does not stop switching.
- R4: When an auto-restart fault occurs, both enables go low and the fault code is held. When `sup_run`=0, the code clears and `hvsrc_en` returns to 1. Switching restarts at the next `sup_on`.
- R5: A latched fault code survives `sup_run` falling and `sup_on` rising again. It clears only on the clock where `sup_rel`=0.
- R6: While a latched code is stored, `sup_on` moves the block from charging to a held state with both enables low. `pwm_en` stays 0.
- R7: Output over-voltage latches only when `vo_high` is 1 at 8 consecutive `cyc_stb` pulses during switching. Any strobe with `vo_high`=0 restarts the count.
- R8: Output under-voltage is an auto-restart fault. It needs `vo_low` at 8 consecutive strobes. It is ignored for the first 45 ms ticks of each switching period.
- R9: Brownout is an auto-restart fault. It fires after `line_weak` has been high for 31 consecutive ms ticks during switching. Any clock with `line_weak`=0 restarts the count. A ms tick occurs every `tick_div`+1 clocks.
- R10: `fault_code` is one-hot and records only the first fault. The bit positions are: 0 output over-voltage, 1 over-temperature, 2 external shutdown, 3 supply over-voltage, 4 output under-voltage, 5 brownout. When several faults fire in the same clock, the lowest bit wins.
- R11: `die_hot` and `ext_shdn` latch and `sup_ovp` trips without debounce, on the clock on which they are seen while switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_on | input | 1 | Supply at or above the turn-on level |
| sup_run | input | 1 | Supply above the turn-off level |
| sup_rel | input | 1 | Supply above the latch-release level |
| sup_ovp | input | 1 | Supply above its over-voltage level |
| vo_high | input | 1 | Sampled output above the over-voltage level |
| vo_low | input | 1 | Sampled output below the under-voltage level |
| line_weak | input | 1 | Line-sense current below the brownout level |
| die_hot | input | 1 | Internal over-temperature flag |
| ext_shdn | input | 1 | External shutdown request |
| cyc_stb | input | 1 | One-clock pulse per switching cycle |
| tick_div | input | 16 | Clocks per ms tick minus one |
| pwm_en | output | 1 | PWM switching enable |
| hvsrc_en | output | 1 | Startup current source enable |
| fault_code | output | 6 | One-hot first-fault code |

## Verification
Some properties are checked on every cycle by assertions:
- the two enables are never high together;
- the fault code stays one-hot;
- a stored latched code does not change while the supply is above the release level;
- switching stays off while a latched code exists;
- no debounce or blanking counter leaves its range.

Other behaviours need the bench's scenarios and its clock-by-clock reference model:
- the exact strobe at which a debounce completes;
- the length of the blanking window;
- the 31-tick brownout window and its restart on a short recovery;
- first-fault priority;
- the different clearing levels of the two fault classes across repeated supply hiccups.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int FCODE_W = 6;
  localparam int B_VO_OV   = 0;
  localparam int B_HOT     = 1;
  localparam int B_SHDN    = 2;
  localparam int B_SUP_OV  = 3;
  localparam int B_VO_UV   = 4;
  localparam int B_BROWN   = 5;
  localparam logic [FCODE_W-1:0] LATCH_MASK = 6'b000111;
  localparam logic [FCODE_W-1:0] AUTO_MASK  = 6'b111000;

  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_HOLD   = 2'd2
  } sup_state_t;
endpackage

// File: rtl/fsup_tick.sv
module fsup_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
    $stable(div) |-> (cnt <= div)); // R9
endmodule

// File: rtl/fsup_persist.sv
module fsup_persist #(
  parameter int N       = 8,
  parameter bit CLR_ANY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic stb,
  input  logic cond,
  output logic hit
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          clr_now;

  generate
    if (CLR_ANY) begin : g_clr_any
      assign clr_now = !cond;
    end else begin : g_clr_stb
      assign clr_now = !cond && stb;
    end
  endgenerate

  assign hit = en && stb && cond && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en)                        cnt <= '0;
    else if (clr_now)                      cnt <= '0;
    else if (stb && cond && cnt != LAST)   cnt <= cnt + 1'b1;
  end

  AST_PERSIST_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R7
  AST_PERSIST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (cnt == '0)); // R7
endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sup_on,
  input  logic sup_run,
  input  logic latched,
  input  logic fault_ev,
  output logic in_run,
  output logic pwm_en,
  output logic hvsrc_en
);
  sup_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_CHARGE: if (sup_on) st_nx = latched ? ST_HOLD : ST_RUN;
      ST_RUN: begin
        if (!sup_run)      st_nx = ST_CHARGE;
        else if (fault_ev) st_nx = ST_HOLD;
      end
      ST_HOLD:   if (!sup_run) st_nx = ST_CHARGE;
      default:   st_nx = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CHARGE;
      pwm_en   <= 1'b0;
      hvsrc_en <= 1'b1;
    end else begin
      st       <= st_nx;
      pwm_en   <= (st_nx == ST_RUN);
      hvsrc_en <= (st_nx == ST_CHARGE);
    end
  end

  assign in_run = (st == ST_RUN);

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pwm_en && hvsrc_en)); // R2
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (in_run && sup_run && fault_ev) |=> !pwm_en); // R4
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OV_CYC   = 8,
  parameter int UV_CYC   = 8,
  parameter int BLANK_MS = 45,
  parameter int BO_MS    = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sup_on,
  input  logic               sup_run,
  input  logic               sup_rel,
  input  logic               sup_ovp,
  input  logic               vo_high,
  input  logic               vo_low,
  input  logic               line_weak,
  input  logic               die_hot,
  input  logic               ext_shdn,
  input  logic               cyc_stb,
  input  logic [DIV_W-1:0]   tick_div,
  output logic               pwm_en,
  output logic               hvsrc_en,
  output logic [FCODE_W-1:0] fault_code
);
  localparam int BO_TICKS = BO_MS + 1;
  localparam int BLK_W    = $clog2(BLANK_MS + 1);
  localparam logic [BLK_W-1:0] BLK_END = BLK_W'(BLANK_MS);

  logic               ms_tick, in_run, run_ok, latched, any_ev;
  logic               hit_ov, hit_uv, hit_bo, uv_armed;
  logic [BLK_W-1:0]   blank_cnt;
  logic [FCODE_W-1:0] ev, ev_first, code_nx;

  fsup_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(tick_div), .tick(ms_tick));

  assign run_ok   = in_run && sup_run;
  assign uv_armed = run_ok && (blank_cnt == BLK_END);
  assign latched  = |(fault_code & LATCH_MASK);

  always_ff @(posedge clk) begin
    if (rst || !in_run)                   blank_cnt <= '0;
    else if (ms_tick && blank_cnt != BLK_END) blank_cnt <= blank_cnt + 1'b1;
  end

  fsup_persist #(.N(OV_CYC), .CLR_ANY(1'b0)) u_ov (
    .clk(clk), .rst(rst), .en(run_ok), .stb(cyc_stb), .cond(vo_high), .hit(hit_ov));
  fsup_persist #(.N(UV_CYC), .CLR_ANY(1'b0)) u_uv (
    .clk(clk), .rst(rst), .en(uv_armed), .stb(cyc_stb), .cond(vo_low), .hit(hit_uv));
  fsup_persist #(.N(BO_TICKS), .CLR_ANY(1'b1)) u_bo (
    .clk(clk), .rst(rst), .en(run_ok), .stb(ms_tick), .cond(line_weak), .hit(hit_bo));

  always_comb begin
    ev           = '0;
    ev[B_VO_OV]  = hit_ov;
    ev[B_HOT]    = run_ok && die_hot;
    ev[B_SHDN]   = run_ok && ext_shdn;
    ev[B_SUP_OV] = run_ok && sup_ovp;
    ev[B_VO_UV]  = hit_uv;
    ev[B_BROWN]  = hit_bo;
  end

  assign any_ev = |ev;

  always_comb begin
    ev_first = '0;
    for (int i = FCODE_W - 1; i >= 0; i--) begin
      if (ev[i]) ev_first = '0;
      if (ev[i]) ev_first[i] = 1'b1;
    end
  end

  always_comb begin
    code_nx = fault_code;
    if (!sup_run) code_nx = code_nx & ~AUTO_MASK;
    if (!sup_rel) code_nx = code_nx & ~LATCH_MASK;
    if (fault_code == '0 && any_ev) code_nx = ev_first;
  end

  always_ff @(posedge clk) begin
    if (rst) fault_code <= '0;
    else     fault_code <= code_nx;
  end

  fsup_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sup_on(sup_on), .sup_run(sup_run),
    .latched(latched), .fault_ev(any_ev), .in_run(in_run),
    .pwm_en(pwm_en), .hvsrc_en(hvsrc_en));

  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_code)); // R10
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (latched && sup_rel) |=> $stable(fault_code)); // R5
  AST_LATCH_NO_PWM: assert property (@(posedge clk) disable iff (rst)
    latched |-> !pwm_en); // R6
  AST_BLANK_RANGE: assert property (@(posedge clk) disable iff (rst)
    blank_cnt <= BLK_END); // R8
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!sup_run) |=> ((fault_code & AUTO_MASK) == '0)); // R4
endmodule

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_on = 0, s_run = 0, s_rel = 0, s_ovp = 0;
  logic vo_h = 0, vo_l = 0, lw = 0, hot = 0, shdn = 0, stb = 0;
  logic [15:0] tdiv = 16'd3;
  logic pwm, hv;
  logic [5:0] code;

  int total = 0, bad = 0, cyc = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  fault_supervisor uut (
    .clk(clk), .rst(rst), .sup_on(s_on), .sup_run(s_run), .sup_rel(s_rel),
    .sup_ovp(s_ovp), .vo_high(vo_h), .vo_low(vo_l), .line_weak(lw),
    .die_hot(hot), .ext_shdn(shdn), .cyc_stb(stb), .tick_div(tdiv),
    .pwm_en(pwm), .hvsrc_en(hv), .fault_code(code));

  // behavioural reference model
  int m_st = 0, m_code = 0, m_tc = 0, m_ov = 0, m_uv = 0, m_bo = 0, m_blank = 0;
  int m_pwm = 0, m_hv = 1;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_code = 0; m_tc = 0; m_ov = 0; m_uv = 0; m_bo = 0;
      m_blank = 0; m_pwm = 0; m_hv = 1;
    end else begin
      bit tk, runok, uven;
      int ev, nc, nst;
      tk = (m_tc == tdiv);
      m_tc = tk ? 0 : m_tc + 1;
      runok = (m_st == 1) && s_run;
      ev = 0;
      if (!runok) m_ov = 0;
      else if (stb) begin
        if (!vo_h) m_ov = 0;
        else if (m_ov == 7) ev |= 1;
        else m_ov++;
      end
      uven = runok && (m_blank == 45);
      if (!uven) m_uv = 0;
      else if (stb) begin
        if (!vo_l) m_uv = 0;
        else if (m_uv == 7) ev |= 16;
        else m_uv++;
      end
      if (m_st != 1) m_blank = 0;
      else if (tk && m_blank < 45) m_blank++;
      if (!runok || !lw) m_bo = 0;
      else if (tk) begin
        if (m_bo == 30) ev |= 32;
        else m_bo++;
      end
      if (runok && hot)   ev |= 2;
      if (runok && shdn)  ev |= 4;
      if (runok && s_ovp) ev |= 8;
      nc = m_code;
      if (!s_run) nc &= 7;
      if (!s_rel) nc &= 56;
      if (m_code == 0 && ev != 0) begin
        for (int b = 0; b < 6; b++)
          if (((ev >> b) & 1) != 0) begin nc = 1 << b; break; end
      end
      nst = m_st;
      case (m_st)
        0: if (s_on) nst = ((m_code & 7) != 0) ? 2 : 1;
        1: if (!s_run) nst = 0; else if (ev != 0) nst = 2;
        default: if (!s_run) nst = 0;
      endcase
      m_code = nc; m_st = nst;
      m_pwm = (nst == 1); m_hv = (nst == 0);
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk({cur, " pwm_en"}, pwm, m_pwm);
    chk({cur, " hvsrc_en"}, hv, m_hv);
    chk({cur, " fault_code"}, code, m_code);
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      stb = 1'b1; step(1); stb = 1'b0; step(5);
    end
  endtask

  task automatic power_up();
    s_rel = 1; s_run = 1; step(2); s_on = 1; step(1); s_on = 0; step(1);
  endtask

  task automatic collapse_to_off();
    s_run = 0; step(2);
  endtask

  initial begin
    step(4);
    chk("R1 pwm", pwm, 0); chk("R1 hv", hv, 1); chk("R1 code", code, 0);
    rst = 0; step(2);
    chk("R1 pwm idle", pwm, 0);

    cur = "R2"; s_rel = 1; s_run = 1; step(2); s_on = 1; step(1);
    chk("R2 pwm", pwm, 1); chk("R2 hv", hv, 0);
    s_on = 0; step(3);
    chk("R3 hysteresis", pwm, 1);
    cur = "R3"; s_run = 0; step(1);
    chk("R3 pwm", pwm, 0); chk("R3 hv", hv, 1);

    cur = "R4"; s_run = 1; s_on = 1; step(1); s_on = 0; step(3);
    s_ovp = 1; step(1); s_ovp = 0;
    chk("R11 sup ovp code", code, 8); chk("R4 pwm", pwm, 0); chk("R4 hv", hv, 0);
    step(5); chk("R4 held", code, 8);
    s_run = 0; step(1);
    chk("R4 cleared", code, 0); chk("R4 recharge", hv, 1);
    s_run = 1; s_on = 1; step(1); s_on = 0;
    chk("R4 restart", pwm, 1);

    cur = "R7"; vo_h = 1; strobes(7); vo_h = 0; strobes(1); vo_h = 1; strobes(7);
    chk("R7 no trip on 7", pwm, 1);
    strobes(1); vo_h = 0;
    chk("R7 latched", code, 1);
    cur = "R6"; collapse_to_off();
    chk("R6 recharge", hv, 1); chk("R5 kept", code, 1);
    s_run = 1; s_on = 1; step(1); s_on = 0; step(1);
    chk("R6 no restart", pwm, 0); chk("R6 hold hv", hv, 0);
    cur = "R5"; collapse_to_off(); s_run = 1; s_on = 1; step(2); s_on = 0;
    chk("R5 kept twice", code, 1);
    s_run = 0; s_rel = 0; step(1);
    chk("R5 released", code, 0);
    step(2);

    cur = "R8"; power_up(); vo_l = 1; strobes(25);
    chk("R8 blanked", pwm, 1); chk("R8 blanked code", code, 0);
    strobes(20); vo_l = 0;
    chk("R8 uv code", code, 16); chk("R8 stopped", pwm, 0);
    collapse_to_off(); chk("R8 auto clear", code, 0);

    cur = "R9"; s_run = 1; s_on = 1; step(1); s_on = 0;
    lw = 1; step(80); lw = 0; step(1);
    chk("R9 short dip", pwm, 1);
    lw = 1; step(31 * 4 + 8); lw = 0;
    chk("R9 brownout code", code, 32); chk("R9 stopped", pwm, 0);
    collapse_to_off();

    cur = "R10"; s_run = 1; s_on = 1; step(1); s_on = 0; step(2);
    hot = 1; shdn = 1; s_ovp = 1; step(1); hot = 0; shdn = 0; s_ovp = 0;
    chk("R10 priority", code, 2);
    s_run = 0; s_rel = 0; step(2); s_rel = 1;

    cur = "R11"; s_run = 1; s_on = 1; step(1); s_on = 0; step(2);
    shdn = 1; step(1); shdn = 0;
    chk("R11 shutdown latch", code, 4); chk("R11 stopped", pwm, 0);
    step(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule